// File: doc/BRIEF.md
# SPI-Addressed Eight-Pin I/O Expander Register File

This block is the register side of an eight-pin general-purpose I/O port, reached over a four-wire serial bus. A host frame begins with a command byte that names a device sub-address and a transfer direction. A register address byte follows, and then any number of data bytes. The block holds eleven 8-bit registers. They set pin direction, the output latch, input inversion and pull-up enables, and they hold the settings that a separate interrupt-detection block uses. Reads return live pin levels for the port register. Reads of the event flags and the captured pin snapshot come straight from that separate block.

Up to eight of these devices can share one chip select. When sub-address matching is switched on in the configuration register, a device acts only on commands whose sub-address equals its three strap inputs. A second configuration bit chooses the addressing mode. In one mode the register address advances after every data byte and wraps past the last register. In the other it stays fixed for the whole frame.

The serial inputs are sampled by the system clock through two-stage synchronizers. The serial clock must therefore run well below the system clock.

Top module: `gpx_spi_expander`

## Requirements
- R1: Frames are SPI mode 0, MSB first, framed by an active-low chip select. The first byte is a command whose bit 0 is 1 for a read and 0 for a write. The second byte is the register address. Every further byte is data.
- R2: After reset, pin_dir is 0xFF (every pin an input). pin_out, pull_en, irq_enable, irq_compare, irq_mode and ctrl_cfg are all 0x00.
- R3: The register addresses are: 0x00 direction, 0x01 input inversion, 0x02 interrupt enable, 0x03 compare value, 0x04 interrupt mode, 0x05 configuration, 0x06 pull-up, 0x07 event flags, 0x08 capture, 0x09 port, 0x0A output latch. Writes to 0x00-0x06 and 0x0A are stored and read back. In the configuration register, bits 7 and 4 always read 0.
- R4: A read of 0x09 returns pin_in XOR the inversion register. A read of 0x08 returns evt_capture XOR the inversion register. A read of 0x07 returns evt_flags unchanged.
- R5: A write to 0x09 updates the output latch. A read of 0x0A returns the latch and not the pin levels.
- R6: With configuration bit 3 set, only commands whose bits 3:1 equal dev_strap are accepted. On any other command the device writes nothing and holds spi_miso at 0.
- R7: With configuration bit 3 clear, command bits 3:1 are ignored.
- R8: With configuration bit 5 clear, the register address advances by one after each data byte, and it wraps from 0x0A (or above) to 0x00. With bit 5 set, the address stays fixed for the whole frame.
- R9: Writes to 0x07 and 0x08, and to any address above 0x0A, change nothing. Reads above 0x0A return 0x00.
- R10: A command whose bits 7:4 are not 0100 is ignored for the rest of the frame.
- R11: spi_miso is 0 while chip select is high and throughout the command and address bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_csn | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| dev_strap | input | 3 | Device sub-address straps |
| pin_in | input | 8 | Live pin levels |
| evt_flags | input | 8 | Event flags from the interrupt-detection block |
| evt_capture | input | 8 | Captured pin snapshot from the interrupt-detection block |
| pin_dir | output | 8 | Direction per pin, 1 = input |
| pin_out | output | 8 | Output latch |
| pull_en | output | 8 | Pull-up enable per pin |
| irq_enable | output | 8 | Interrupt enable per pin |
| irq_compare | output | 8 | Compare value per pin |
| irq_mode | output | 8 | Interrupt mode per pin |
| ctrl_cfg | output | 8 | Configuration register |

## Verification
Each rising serial-clock edge reaches the shift register three system clocks later. A written register shows on its output port one clock after that. The next spi_miso bit changes about three clocks after the rising edge it follows, and a fresh read byte is loaded about five clocks after the last rising edge of the previous byte. The bench holds every serial-clock phase for eight system clocks. It samples spi_miso at the end of each low phase, so every bit has settled before the host-side edge. It compares the register outputs only after chip select has returned high and a further gap has passed.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int REG_W    = 8;
  localparam int STRAP_W  = 3;
  localparam int NUM_REGS = 11;

  localparam logic [REG_W-1:0] RA_DIR  = 8'h00;
  localparam logic [REG_W-1:0] RA_POL  = 8'h01;
  localparam logic [REG_W-1:0] RA_IEN  = 8'h02;
  localparam logic [REG_W-1:0] RA_CMP  = 8'h03;
  localparam logic [REG_W-1:0] RA_ICTL = 8'h04;
  localparam logic [REG_W-1:0] RA_CFG  = 8'h05;
  localparam logic [REG_W-1:0] RA_PUP  = 8'h06;
  localparam logic [REG_W-1:0] RA_FLG  = 8'h07;
  localparam logic [REG_W-1:0] RA_CAP  = 8'h08;
  localparam logic [REG_W-1:0] RA_PORT = 8'h09;
  localparam logic [REG_W-1:0] RA_LAT  = 8'h0A;
  localparam logic [REG_W-1:0] LAST_ADDR = RA_LAT;

  localparam logic [3:0]       OPCODE   = 4'b0100;
  localparam int               CFG_SEQ_OFF = 5;
  localparam int               CFG_HAEN    = 3;
  localparam logic [REG_W-1:0] CFG_MASK = 8'h6F;

  typedef enum logic [1:0] {F_CMD, F_ADDR, F_DATA, F_SKIP} frame_e;

  function automatic logic [REG_W-1:0] reg_rst_val(input logic [REG_W-1:0] a);
    return (a == RA_DIR) ? {REG_W{1'b1}} : '0;
  endfunction

  function automatic logic [REG_W-1:0] reg_wmask(input logic [REG_W-1:0] a);
    return (a == RA_CFG) ? CFG_MASK : {REG_W{1'b1}};
  endfunction

  function automatic logic reg_stored(input logic [REG_W-1:0] a);
    return (a <= LAST_ADDR) && (a != RA_FLG) && (a != RA_CAP) && (a != RA_PORT);
  endfunction
endpackage

// File: rtl/gpx_spi_shift.sv
module gpx_spi_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sclk,
  input  logic         csn,
  input  logic         mosi,
  input  logic         load,
  input  logic [W-1:0] load_data,
  output logic         sel,
  output logic         byte_done,
  output logic [W-1:0] rx_byte,
  output logic         miso
);
  localparam int CW = $clog2(W);

  logic [2:0]    sclk_q;
  logic [1:0]    csn_q;
  logic [1:0]    mosi_q;
  logic          rise;
  logic [CW-1:0] cnt;
  logic [W-1:0]  sh;
  logic [W-1:0]  sh_next;
  logic [W-1:0]  tx;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= '0;
      csn_q  <= '1;
      mosi_q <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      csn_q  <= {csn_q[0], csn};
      mosi_q <= {mosi_q[0], mosi};
    end
  end

  assign sel     = ~csn_q[1];
  assign rise    = sclk_q[1] & ~sclk_q[2];
  assign sh_next = {sh[W-2:0], mosi_q[1]};

  always_ff @(posedge clk) begin
    if (rst || !sel) begin
      cnt       <= '0;
      sh        <= '0;
      tx        <= '0;
      byte_done <= 1'b0;
      rx_byte   <= '0;
    end else begin
      byte_done <= 1'b0;
      if (rise) begin
        sh <= sh_next;
        tx <= {tx[W-2:0], 1'b0};
        if (cnt == CW'(W-1)) begin
          cnt       <= '0;
          byte_done <= 1'b1;
          rx_byte   <= sh_next;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (load) tx <= load_data;
    end
  end

  assign miso = tx[W-1];

  // R11: the response line goes quiet once the device is deselected
  p_miso_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !sel |=> !miso);
endmodule

// File: rtl/gpx_frame_ctrl.sv
module gpx_frame_ctrl
  import gpx_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               sel,
  input  logic               byte_done,
  input  logic [REG_W-1:0]   rx_byte,
  input  logic [STRAP_W-1:0] strap,
  input  logic               seq_off,
  input  logic               haen,
  output logic [REG_W-1:0]   cur_addr,
  output logic               wr_en,
  output logic               rd_load
);
  frame_e           st;
  logic             rd_mode;
  logic             hit;
  logic [REG_W-1:0] next_addr;

  assign hit = (rx_byte[7:4] == OPCODE) &&
               (!haen || (rx_byte[STRAP_W:1] == strap));

  assign next_addr = seq_off ? cur_addr :
                     (cur_addr >= LAST_ADDR) ? '0 : cur_addr + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || !sel) begin
      st      <= F_CMD;
      rd_mode <= 1'b0;
      rd_load <= 1'b0;
    end else begin
      rd_load <= 1'b0;
      if (byte_done) begin
        case (st)
          F_CMD: begin
            st      <= hit ? F_ADDR : F_SKIP;
            rd_mode <= rx_byte[0];
          end
          F_ADDR: begin
            st      <= F_DATA;
            rd_load <= rd_mode;
          end
          F_DATA:  rd_load <= rd_mode;
          default: st <= F_SKIP;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
    end else if (sel && byte_done) begin
      if (st == F_ADDR)      cur_addr <= rx_byte;
      else if (st == F_DATA) cur_addr <= next_addr;
    end
  end

  assign wr_en = byte_done && (st == F_DATA) && !rd_mode;

  // R8: auto-increment wraps after the last register
  p_addr_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (sel && byte_done && st == F_DATA && !seq_off && cur_addr == LAST_ADDR)
      |=> cur_addr == '0);
  // R8: fixed addressing holds the pointer
  p_addr_fixed_r8: assert property (@(posedge clk) disable iff (rst)
    (sel && byte_done && st == F_DATA && seq_off) |=> $stable(cur_addr));
  // R6: a rejected frame neither writes nor loads read data
  p_skip_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (st == F_SKIP) |-> (!wr_en && !rd_load));
endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
  import gpx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic [REG_W-1:0] pin_in,
  input  logic [REG_W-1:0] evt_flags,
  input  logic [REG_W-1:0] evt_capture,
  output logic [REG_W-1:0] rd_data,
  output logic [REG_W-1:0] r_dir,
  output logic [REG_W-1:0] r_pol,
  output logic [REG_W-1:0] r_ien,
  output logic [REG_W-1:0] r_cmp,
  output logic [REG_W-1:0] r_ictl,
  output logic [REG_W-1:0] r_cfg,
  output logic [REG_W-1:0] r_pup,
  output logic [REG_W-1:0] r_lat
);
  localparam int IW = $clog2(NUM_REGS);

  logic [REG_W-1:0] store [NUM_REGS];
  logic [REG_W-1:0] eff_addr;
  logic             wr_ok;

  // a port write lands in the output latch
  assign eff_addr = (addr == RA_PORT) ? RA_LAT : addr;
  assign wr_ok    = wr_en && reg_stored(eff_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) store[i] <= reg_rst_val(REG_W'(i));
    end else if (wr_ok) begin
      store[eff_addr[IW-1:0]] <= wr_data & reg_wmask(eff_addr);
    end
  end

  always_comb begin
    case (addr)
      RA_PORT: rd_data = pin_in ^ store[RA_POL[IW-1:0]];
      RA_CAP:  rd_data = evt_capture ^ store[RA_POL[IW-1:0]];
      RA_FLG:  rd_data = evt_flags;
      default: rd_data = (addr <= LAST_ADDR) ? store[addr[IW-1:0]] : '0;
    endcase
  end

  assign r_dir  = store[RA_DIR[IW-1:0]];
  assign r_pol  = store[RA_POL[IW-1:0]];
  assign r_ien  = store[RA_IEN[IW-1:0]];
  assign r_cmp  = store[RA_CMP[IW-1:0]];
  assign r_ictl = store[RA_ICTL[IW-1:0]];
  assign r_cfg  = store[RA_CFG[IW-1:0]];
  assign r_pup  = store[RA_PUP[IW-1:0]];
  assign r_lat  = store[RA_LAT[IW-1:0]];

  // R2: reset leaves every pin an input and the latch clear
  p_reset_vals_r2: assert property (@(posedge clk)
    $past(rst) |-> (r_dir == 8'hFF && r_lat == 8'h00 && r_cfg == 8'h00));
  // R9: a write aimed at a read-only register leaves the stored state alone
  p_ro_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == RA_FLG || addr == RA_CAP))
      |=> ($stable(r_dir) && $stable(r_lat) && $stable(r_cfg) && $stable(r_pup)));
endmodule

// File: rtl/gpx_spi_expander.sv
module gpx_spi_expander
  import gpx_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               spi_sclk,
  input  logic               spi_csn,
  input  logic               spi_mosi,
  output logic               spi_miso,
  input  logic [STRAP_W-1:0] dev_strap,
  input  logic [REG_W-1:0]   pin_in,
  input  logic [REG_W-1:0]   evt_flags,
  input  logic [REG_W-1:0]   evt_capture,
  output logic [REG_W-1:0]   pin_dir,
  output logic [REG_W-1:0]   pin_out,
  output logic [REG_W-1:0]   pull_en,
  output logic [REG_W-1:0]   irq_enable,
  output logic [REG_W-1:0]   irq_compare,
  output logic [REG_W-1:0]   irq_mode,
  output logic [REG_W-1:0]   ctrl_cfg
);
  logic             sel;
  logic             byte_done;
  logic [REG_W-1:0] rx_byte;
  logic [REG_W-1:0] cur_addr;
  logic             wr_en;
  logic             rd_load;
  logic [REG_W-1:0] rd_data;
  logic [REG_W-1:0] pol_unused;

  gpx_spi_shift #(.W(REG_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .sclk      (spi_sclk),
    .csn       (spi_csn),
    .mosi      (spi_mosi),
    .load      (rd_load),
    .load_data (rd_data),
    .sel       (sel),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .miso      (spi_miso)
  );

  gpx_frame_ctrl u_frame (
    .clk       (clk),
    .rst       (rst),
    .sel       (sel),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .strap     (dev_strap),
    .seq_off   (ctrl_cfg[CFG_SEQ_OFF]),
    .haen      (ctrl_cfg[CFG_HAEN]),
    .cur_addr  (cur_addr),
    .wr_en     (wr_en),
    .rd_load   (rd_load)
  );

  gpx_regfile u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .addr        (cur_addr),
    .wr_data     (rx_byte),
    .pin_in      (pin_in),
    .evt_flags   (evt_flags),
    .evt_capture (evt_capture),
    .rd_data     (rd_data),
    .r_dir       (pin_dir),
    .r_pol       (pol_unused),
    .r_ien       (irq_enable),
    .r_cmp       (irq_compare),
    .r_ictl      (irq_mode),
    .r_cfg       (ctrl_cfg),
    .r_pup       (pull_en),
    .r_lat       (pin_out)
  );

  // R5: the output latch only moves on an accepted write
  p_lat_write_r5: assert property (@(posedge clk) disable iff (rst)
    (!wr_en) |=> $stable(pin_out));
endmodule

// File: tb/tb_gpx_spi_expander.sv
module tb_gpx_spi_expander;
  localparam int HALF = 8;
  localparam logic [2:0] STRAP = 3'b101;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       spi_sclk = 1'b0, spi_csn = 1'b1, spi_mosi = 1'b0;
  logic       spi_miso;
  logic [2:0] dev_strap = STRAP;
  logic [7:0] pin_in = 8'h00, evt_flags = 8'h00, evt_capture = 8'h00;
  logic [7:0] pin_dir, pin_out, pull_en, irq_enable, irq_compare, irq_mode, ctrl_cfg;

  always #2.5 clk = ~clk;

  gpx_spi_expander dut (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_csn(spi_csn),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .dev_strap(dev_strap),
    .pin_in(pin_in), .evt_flags(evt_flags), .evt_capture(evt_capture),
    .pin_dir(pin_dir), .pin_out(pin_out), .pull_en(pull_en),
    .irq_enable(irq_enable), .irq_compare(irq_compare),
    .irq_mode(irq_mode), .ctrl_cfg(ctrl_cfg)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] m [0:10];
  logic [7:0] tx_buf [0:9];
  logic [7:0] rx_buf [0:9];
  logic [7:0] wdat [0:7];

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h09:   return pin_in ^ m[1];
      8'h08:   return evt_capture ^ m[1];
      8'h07:   return evt_flags;
      default: return (a <= 8'h0A) ? m[a[3:0]] : 8'h00;
    endcase
  endfunction

  function automatic bit accepted(input logic [7:0] cmd);
    return (cmd[7:4] == 4'b0100) && (!m[5][3] || cmd[3:1] == STRAP);
  endfunction

  task automatic xfer(input int n);
    spi_csn = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      for (int b = 7; b >= 0; b--) begin
        spi_mosi = tx_buf[k][b];
        repeat (HALF) @(negedge clk);
        rx_buf[k][b] = spi_miso;
        spi_sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        spi_sclk = 1'b0;
      end
    end
    repeat (HALF) @(negedge clk);
    spi_csn = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  // one full frame; the model tracks writes and predicts reads (R1)
  task automatic run_frame(input logic [7:0] cmd, input logic [7:0] a,
                           input int nd, input string tag);
    bit ok, seq_old;
    logic [7:0] ad, eff;
    ok = accepted(cmd);
    tx_buf[0] = cmd;
    tx_buf[1] = a;
    for (int k = 0; k < nd; k++) tx_buf[2 + k] = wdat[k];
    xfer(nd + 2);
    check({tag, " R11 cmd byte"}, 64'(rx_buf[0]), 64'h0);
    check({tag, " R11 addr byte"}, 64'(rx_buf[1]), 64'h0);
    ad = a;
    for (int k = 0; k < nd; k++) begin
      if (cmd[0]) begin
        check({tag, " R1 read data"}, 64'(rx_buf[2 + k]), ok ? 64'(exp_rd(ad)) : 64'h0);
      end
      if (ok) begin
        seq_old = m[5][5];
        if (!cmd[0]) begin
          eff = (ad == 8'h09) ? 8'h0A : ad;
          if (eff <= 8'h0A && eff != 8'h07 && eff != 8'h08)
            m[eff[3:0]] = wdat[k] & ((eff == 8'h05) ? 8'h6F : 8'hFF);
        end
        ad = seq_old ? ad : ((ad >= 8'h0A) ? 8'h00 : ad + 8'h01);
      end
    end
    check({tag, " R3 outputs"},
          {8'h0, pin_dir, pin_out, pull_en, irq_enable, irq_compare, irq_mode, ctrl_cfg},
          {8'h0, m[0], m[10], m[6], m[2], m[3], m[4], m[5]});
  endtask

  initial begin
    for (int i = 0; i < 11; i++) m[i] = (i == 0) ? 8'hFF : 8'h00;
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R2 reset state
    check("R2 reset outputs",
          {8'h0, pin_dir, pin_out, pull_en, irq_enable, irq_compare, irq_mode, ctrl_cfg},
          {8'h0, 8'hFF, 48'h0});
    check("R11 idle miso", 64'(spi_miso), 64'h0);

    // R3 sequential write of the first five registers
    wdat[0] = 8'h0F; wdat[1] = 8'hA5; wdat[2] = 8'h3C; wdat[3] = 8'h81; wdat[4] = 8'h7E;
    run_frame({4'b0100, STRAP, 1'b0}, 8'h00, 5, "R3 seq write");
    wdat[0] = 8'hC3;
    run_frame({4'b0100, STRAP, 1'b0}, 8'h06, 1, "R3 pull-up");
    wdat[0] = 8'hFF;
    run_frame({4'b0100, STRAP, 1'b0}, 8'h05, 1, "R3 cfg mask");
    check("R3 cfg bits 7 and 4 read 0", 64'(ctrl_cfg), 64'h6F);
    wdat[0] = 8'h08;
    run_frame({4'b0100, STRAP, 1'b0}, 8'h05, 1, "R3 cfg set");

    // R5 port write goes to latch; latch read is not the pins
    wdat[0] = 8'h3C;
    run_frame({4'b0100, STRAP, 1'b0}, 8'h09, 1, "R5 port write");
    check("R5 latch output", 64'(pin_out), 64'h3C);
    pin_in = 8'h96;
    run_frame({4'b0100, STRAP, 1'b1}, 8'h0A, 1, "R5 latch read");

    // R4 flags, capture and inverted port
    evt_flags = 8'h12; evt_capture = 8'hF0; pin_in = 8'h5A;
    run_frame({4'b0100, STRAP, 1'b1}, 8'h07, 3, "R4 volatile read");

    // R9 read-only and out-of-range
    wdat[0] = 8'hEE; wdat[1] = 8'hDD;
    run_frame({4'b0100, STRAP, 1'b0}, 8'h07, 2, "R9 ro write");
    run_frame({4'b0100, STRAP, 1'b1}, 8'h07, 2, "R9 ro readback");
    wdat[0] = 8'h55;
    run_frame({4'b0100, STRAP, 1'b0}, 8'h0C, 1, "R9 high write");
    run_frame({4'b0100, STRAP, 1'b1}, 8'h0C, 1, "R9 high read");

    // R8 wrap from the last register to the first
    wdat[0] = 8'h11; wdat[1] = 8'h22;
    run_frame({4'b0100, STRAP, 1'b0}, 8'h0A, 2, "R8 wrap");
    check("R8 wrap reached direction", 64'(pin_dir), 64'h22);

    // R8 fixed addressing
    wdat[0] = 8'h28;
    run_frame({4'b0100, STRAP, 1'b0}, 8'h05, 1, "R8 seq off");
    wdat[0] = 8'h01; wdat[1] = 8'h02; wdat[2] = 8'h03;
    run_frame({4'b0100, STRAP, 1'b0}, 8'h06, 3, "R8 fixed write");
    check("R8 fixed keeps last", 64'(pull_en), 64'h03);
    run_frame({4'b0100, STRAP, 1'b1}, 8'h00, 3, "R8 fixed read");
    wdat[0] = 8'h08;
    run_frame({4'b0100, STRAP, 1'b0}, 8'h05, 1, "R8 seq on");

    // R6 sub-address matching enabled
    wdat[0] = 8'h99;
    run_frame({4'b0100, 3'b010, 1'b0}, 8'h0A, 1, "R6 mismatch write");
    check("R6 latch unchanged", 64'(pin_out), 64'h11);
    run_frame({4'b0100, 3'b010, 1'b1}, 8'h00, 2, "R6 mismatch read");
    run_frame({4'b0100, STRAP, 1'b0}, 8'h0A, 1, "R6 match write");

    // R7 sub-address ignored when matching is off
    wdat[0] = 8'h00;
    run_frame({4'b0100, STRAP, 1'b0}, 8'h05, 1, "R7 haen off");
    wdat[0] = 8'h4B;
    run_frame({4'b0100, 3'b011, 1'b0}, 8'h0A, 1, "R7 any sub-address");
    check("R7 latch written", 64'(pin_out), 64'h4B);

    // R10 wrong opcode
    wdat[0] = 8'hA0;
    run_frame(8'h60, 8'h0A, 1, "R10 bad opcode write");
    check("R10 latch unchanged", 64'(pin_out), 64'h4B);
    run_frame(8'h41 | 8'h20, 8'h00, 1, "R10 bad opcode read");

    // random frames, R1 through R10 against the model
    for (int it = 0; it < 40; it++) begin
      logic [7:0] cmd;
      pin_in = 8'($urandom); evt_flags = 8'($urandom); evt_capture = 8'($urandom);
      cmd = {(($urandom % 8) == 0) ? 4'b0110 : 4'b0100,
             (($urandom % 3) == 0) ? 3'($urandom) : STRAP, 1'($urandom)};
      for (int k = 0; k < 4; k++) wdat[k] = 8'($urandom);
      run_frame(cmd, 8'($urandom % 13), 1 + int'($urandom % 4), "R1 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule